// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management register file of one Ethernet PHY, as seen from the MAC's management frame register. The MAC side presents a 32-bit command word. The word selects read or write, names a 9-bit register address and carries 16 bits of write data. Each accepted command completes in a single clock. A read loads the addressed value into the frame register. A write leaves the command word there. Either kind raises a one-cycle completion pulse, which the MAC interrupt logic latches.

The model keeps control, status, advertisement, interrupt-source and interrupt-mask registers, plus four read-only identity and capability constants. A link-level input is edge-detected. Each transition updates the link and autonegotiation status bits and posts interrupt-source bits. The interrupt-source register clears when it is read. Autonegotiation completes as soon as it is requested.

The command input is a valid/ready stream with no back-pressure beyond reset. `cmd_ready` is high in every cycle where reset is released. A word is taken on each rising edge where `cmd_valid` and `cmd_ready` are both high. The result is then visible on the frame output and the completion pulse one cycle later.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Command word fields: bit 28 set means write and clear means read; bits 26:18 are the register address; bits 15:0 are the write data. `cmd_ready` is high whenever reset is not asserted, and back-to-back commands are taken one per cycle.
- R2: In the cycle after each accepted command, `mgmt_done` is high for exactly one cycle. Otherwise it is low. After a write, `frame_out` equals the command word. After a read, it equals the 16-bit register value, zero-extended.
- R3: After reset the registers read as follows: control 0x3000, status 0x7809, advertisement 0x01E1, interrupt source 0, interrupt mask 0. After reset, `frame_out` is 0 and `mgmt_done` is 0.
- R4: A write to register 0 with data bit 15 set restores every register to its R3 value and re-arms link edge detection, so a link that is high is seen rising again on the next cycle. Without bit 15, control becomes data AND 0x7980. If data bit 12 is also set, status bit 5 is set in the same cycle.
- R5: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R6: Registers 2, 3, 5 and 6 read 0x0007, 0xC0D1, 0x0F71 and 0x0001, and writes to them have no effect.
- R7: A read of register 29 returns the interrupt-source bits and then clears them. Register 30 stores the low 8 bits of written data and reads them back.
- R8: A rising edge on `link_up` sets status bits 2 and 5 and interrupt-source bits 7 and 6. A falling edge clears status bits 2 and 5 and sets source bit 4. Each transition posts its bits once.
- R9: Addresses 32 to 511 read zero and ignore writes, and bits 8:5 of the address must be decoded. Other addresses below 32 with no register read zero. The status register (1) ignores writes.
- R10: A link edge in the same cycle as a command takes effect after the command. A read of register 29 keeps the newly posted source bit. A falling edge overrides status bit 5 set by a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command can be taken (high outside reset) |
| cmd_word | input | 32 | Management command word |
| link_up | input | 1 | Link level from the line side, synchronous to clk |
| frame_out | output | 32 | Frame register: last command word, or read data |
| mgmt_done | output | 1 | One-cycle pulse per completed command |

## Verification
The hardest case to reach from the ports is a link edge in the very cycle a command touches the same state. Examples are a read of the interrupt-source register, a control write asking for autonegotiation, and a soft reset. The bench drives `link_up` and the command from the same task on the same falling edge, so both reach the same rising edge. It then reads the registers back to see which effect won. Addresses above 31 whose low five bits alias real registers are used to expose a shortened address decode.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int REGA_W   = 9;
  localparam int WR_BIT   = 28;
  localparam int ADDR_LSB = 18;
  localparam int NUM_REGS = 32;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int IRQ_W    = 8;

  localparam int RI_CTRL = 0;
  localparam int RI_STAT = 1;
  localparam int RI_ID1  = 2;
  localparam int RI_ID2  = 3;
  localparam int RI_ADV  = 4;
  localparam int RI_LPA  = 5;
  localparam int RI_EXP  = 6;
  localparam int RI_SRC  = 29;
  localparam int RI_MSK  = 30;

  localparam logic [DATA_W-1:0] CTRL_INIT  = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_INIT  = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_INIT   = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
  localparam logic [DATA_W-1:0] ID1_VAL    = 16'h0007;
  localparam logic [DATA_W-1:0] ID2_VAL    = 16'hC0D1;
  localparam logic [DATA_W-1:0] LPA_VAL    = 16'h0F71;
  localparam logic [DATA_W-1:0] EXP_VAL    = 16'h0001;
  localparam logic [DATA_W-1:0] STAT_LINK  = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;

  localparam int CTRL_RST_BIT = 15;
  localparam int CTRL_AN_BIT  = 12;

  localparam logic [IRQ_W-1:0] SRC_UP   = 8'hC0;
  localparam logic [IRQ_W-1:0] SRC_DOWN = 8'h10;

  typedef struct packed {
    logic              wr;
    logic [REGA_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;
endpackage

// File: rtl/link_monitor.sv
module link_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic link_in,
  output logic went_up,
  output logic went_down
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level_q <= 1'b0;
    else if (rearm) level_q <= 1'b0;
    else            level_q <= link_in;
  end

  assign went_up   = link_in & ~level_q;
  assign went_down = ~link_in & level_q;

  // R8
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (went_up && !rearm) |=> !went_up);
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import phy_mgmt_pkg::*;
#(
  parameter int NREG = NUM_REGS
) (
  input  logic [CMD_W-1:0] word,
  input  logic             take,
  output mgmt_cmd_t        cmd,
  output logic             wr_en,
  output logic             rd_en,
  output logic [NREG-1:0]  sel
);
  localparam int LOW_W = $clog2(NREG);

  logic in_range;

  always_comb begin
    cmd.wr   = word[WR_BIT];
    cmd.addr = word[ADDR_LSB +: REGA_W];
    cmd.data = word[DATA_W-1:0];
  end

  assign in_range = (cmd.addr[REGA_W-1:LOW_W] == '0);
  assign wr_en    = take & cmd.wr;
  assign rd_en    = take & ~cmd.wr;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = in_range && (cmd.addr[LOW_W-1:0] == LOW_W'(i));
  end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int MW   = IRQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NREG-1:0]   sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_rise,
  input  logic              link_fall,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst
);
  logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
  logic [MW-1:0]     src_q, msk_q;
  logic [DATA_W-1:0] stat_d;
  logic [MW-1:0]     src_d;

  assign soft_rst = wr_en & sel[RI_CTRL] & wdata[CTRL_RST_BIT];

  always_comb begin
    rdata = '0;
    if (sel[RI_CTRL]) rdata = ctrl_q;
    if (sel[RI_STAT]) rdata = stat_q;
    if (sel[RI_ID1])  rdata = ID1_VAL;
    if (sel[RI_ID2])  rdata = ID2_VAL;
    if (sel[RI_ADV])  rdata = adv_q;
    if (sel[RI_LPA])  rdata = LPA_VAL;
    if (sel[RI_EXP])  rdata = EXP_VAL;
    if (sel[RI_SRC])  rdata = DATA_W'(src_q);
    if (sel[RI_MSK])  rdata = DATA_W'(msk_q);
  end

  // command effect first, link edge applied on top of it
  always_comb begin
    stat_d = stat_q;
    if (wr_en && sel[RI_CTRL] && wdata[CTRL_AN_BIT]) stat_d = stat_d | STAT_ANDONE;
    if (link_rise) stat_d = stat_d | STAT_LINK;
    if (link_fall) stat_d = stat_d & ~STAT_LINK;
    src_d = (rd_en && sel[RI_SRC]) ? '0 : src_q;
    if (link_rise) src_d = src_d | SRC_UP;
    if (link_fall) src_d = src_d | SRC_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= STAT_INIT;
      adv_q  <= ADV_INIT;
      src_q  <= '0;
      msk_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= STAT_INIT;
      adv_q  <= ADV_INIT;
      src_q  <= '0;
      msk_q  <= '0;
    end else begin
      if (wr_en && sel[RI_CTRL]) ctrl_q <= wdata & CTRL_KEEP;
      if (wr_en && sel[RI_ADV])  adv_q  <= (wdata & ADV_KEEP) | ADV_FORCE;
      if (wr_en && sel[RI_MSK])  msk_q  <= wdata[MW-1:0];
      stat_q <= stat_d;
      src_q  <= src_d;
    end
  end

  // R4
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[RI_CTRL] && !wdata[CTRL_RST_BIT]) |=> ctrl_q == ($past(wdata) & CTRL_KEEP));
  // R5
  adv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[RI_ADV]) |=> adv_q == (($past(wdata) & ADV_KEEP) | ADV_FORCE));
  // R7
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel[RI_SRC] && !link_rise && !link_fall) |=> src_q == '0);
  // R8
  link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rise && !soft_rst) |=> (stat_q[2] && stat_q[5] && src_q[7] && src_q[6]));
  // R8
  link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fall && !soft_rst) |=> (!stat_q[2] && !stat_q[5] && src_q[4]));
  // R10
  keep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel[RI_SRC] && link_fall) |=> src_q == SRC_DOWN);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int MW   = IRQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             link_up,
  output logic [CMD_W-1:0] frame_out,
  output logic             mgmt_done
);
  mgmt_cmd_t         cmd;
  logic              take, wr_en, rd_en, soft_rst, rise, fall;
  logic [NREG-1:0]   sel;
  logic [DATA_W-1:0] rdata;
  logic [CMD_W-1:0]  frame_q;
  logic              done_q;

  assign cmd_ready = rst_n;
  assign take      = cmd_valid & cmd_ready;

  cmd_decoder #(.NREG(NREG)) u_dec (
    .word (cmd_word),
    .take (take),
    .cmd  (cmd),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .sel  (sel)
  );

  link_monitor u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .rearm    (soft_rst),
    .link_in  (link_up),
    .went_up  (rise),
    .went_down(fall)
  );

  phy_reg_bank #(.NREG(NREG), .MW(MW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sel      (sel),
    .wdata    (cmd.data),
    .link_rise(rise & ~soft_rst),
    .link_fall(fall & ~soft_rst),
    .rdata    (rdata),
    .soft_rst (soft_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take;
      if (take) frame_q <= cmd.wr ? cmd_word : CMD_W'(rdata);
    end
  end

  assign frame_out = frame_q;
  assign mgmt_done = done_q;

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mgmt_done);
  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_done |-> $past(take));
  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd.addr[REGA_W-1:SEL_W] != '0) |=> frame_out == '0);
  // R2
  write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> frame_out == $past(cmd_word));
endmodule

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        link_up = 1'b0;
  logic [31:0] frame_out;
  logic        mgmt_done;

  always #2.5 clk = ~clk;

  phy_mgmt_regs uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .link_up(link_up), .frame_out(frame_out), .mgmt_done(mgmt_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [15:0] m_ctrl, m_stat, m_adv;
  logic [7:0]  m_src, m_msk;
  bit          m_link;
  logic [31:0] m_frame;
  bit          m_done;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
    m_src = 0; m_msk = 0; m_link = 0;
  endtask

  function automatic logic [15:0] model_read(int a);
    case (a)
      0:  return m_ctrl;
      1:  return m_stat;
      2:  return 16'h0007;
      3:  return 16'hC0D1;
      4:  return m_adv;
      5:  return 16'h0F71;
      6:  return 16'h0001;
      29: return {8'h00, m_src};
      30: return {8'h00, m_msk};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step(bit v, logic [31:0] w, bit lk);
    bit up, dn, sr;
    int a;
    logic [15:0] d;
    up = lk && !m_link;
    dn = !lk && m_link;
    m_link = lk;
    sr = 0;
    m_done = v;
    if (v) begin
      a = int'(w[26:18]);
      d = w[15:0];
      if (w[28]) begin
        m_frame = w;
        if (a == 0) begin
          if (d[15]) begin
            model_reset();
            sr = 1;
          end else begin
            m_ctrl = d & 16'h7980;
            if (d[12]) m_stat[5] = 1'b1;
          end
        end else if (a == 4) m_adv = (d & 16'h2D7F) | 16'h0080;
        else if (a == 30) m_msk = d[7:0];
      end else begin
        m_frame = {16'h0000, model_read(a)};
        if (a == 29) m_src = 0;
      end
    end
    if (!sr) begin
      if (up) begin m_stat[2] = 1; m_stat[5] = 1; m_src[7] = 1; m_src[6] = 1; end
      if (dn) begin m_stat[2] = 0; m_stat[5] = 0; m_src[4] = 1; end
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(bit v, logic [31:0] w, bit lk);
    cmd_valid = v;
    cmd_word  = w;
    link_up   = lk;
    @(posedge clk);
    model_step(v, w, lk);
    @(negedge clk);
    check("R2 model frame_out", frame_out, m_frame);
    check("R2 model mgmt_done", {31'b0, mgmt_done}, {31'b0, m_done});
  endtask

  function automatic logic [31:0] mk(bit wr, int a, logic [15:0] d);
    return (32'(wr) << 28) | ((32'(a) & 32'h1FF) << 18) | {16'h0, d};
  endfunction

  task automatic rd(int a, logic [15:0] exp, string tag);
    step(1, mk(0, a, 16'h0), link_up);
    check(tag, frame_out, {16'h0, exp});
  endtask

  task automatic wr(int a, logic [15:0] d);
    step(1, mk(1, a, d), link_up);
  endtask

  task automatic idle(bit lk);
    step(0, 32'h0, lk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    m_frame = 0; m_done = 0;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {31'b0, cmd_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, cmd_ready}, 32'd1);
    check("R3 frame reset", frame_out, 32'h0);
    check("R3 done reset", {31'b0, mgmt_done}, 32'd0);

    rd(0, 16'h3000, "R3 ctrl");
    rd(1, 16'h7809, "R3 status");
    rd(4, 16'h01E1, "R3 adv");
    rd(29, 16'h0000, "R3 source");
    rd(30, 16'h0000, "R3 mask");
    rd(2, 16'h0007, "R6 id1");
    rd(3, 16'hC0D1, "R6 id2");
    rd(5, 16'h0F71, "R6 partner");
    rd(6, 16'h0001, "R6 expansion");
    wr(2, 16'hFFFF);
    check("R2 write echo", frame_out, mk(1, 2, 16'hFFFF));
    check("R2 done after write", {31'b0, mgmt_done}, 32'd1);
    rd(2, 16'h0007, "R6 write ignored");

    wr(0, 16'h7FFF);
    rd(0, 16'h7980, "R4 ctrl mask");
    rd(1, 16'h7829, "R4 an complete");
    wr(0, 16'h0000);
    rd(0, 16'h0000, "R4 ctrl clear");
    wr(4, 16'hFFFF);
    rd(4, 16'h2DFF, "R5 adv ones");
    wr(4, 16'h0000);
    rd(4, 16'h0080, "R5 adv forced");
    wr(30, 16'h1234);
    rd(30, 16'h0034, "R7 mask 8 bits");
    wr(1, 16'h0000);
    rd(1, 16'h7829, "R9 status not writable");

    idle(1);
    check("R2 no done when idle", {31'b0, mgmt_done}, 32'd0);
    rd(1, 16'h782D, "R8 link up status");
    rd(29, 16'h00C0, "R8 link up source");
    rd(29, 16'h0000, "R7 source cleared");
    idle(1);
    rd(29, 16'h0000, "R8 posted once");
    idle(0);
    rd(1, 16'h7809, "R8 link down status");
    rd(29, 16'h0010, "R8 link down source");
    rd(29, 16'h0000, "R7 cleared again");

    step(1, mk(0, 29, 16'h0), 1'b1);
    check("R10 read old source", frame_out, 32'h0);
    rd(29, 16'h00C0, "R10 event kept after clear");
    step(1, mk(1, 0, 16'h1000), 1'b0);
    rd(0, 16'h1000, "R4 ctrl an bit");
    rd(1, 16'h7809, "R10 link down wins");
    rd(29, 16'h0010, "R10 down source");

    rd(32, 16'h0000, "R9 addr 32 reads zero");
    rd(9'h1FF, 16'h0000, "R9 addr 511 reads zero");
    wr(32, 16'h0000);
    rd(0, 16'h1000, "R9 write above 31 ignored");
    wr(36, 16'hFFFF);
    rd(4, 16'h0080, "R9 alias write ignored");
    rd(17, 16'h0000, "R9 undefined reg");
    rd(31, 16'h0000, "R9 reg 31");

    idle(1);
    wr(30, 16'h00FF);
    step(1, mk(1, 0, 16'h8000), 1'b1);
    rd(0, 16'h3000, "R4 soft reset ctrl");
    rd(30, 16'h0000, "R4 soft reset mask");
    rd(1, 16'h782D, "R4 rearmed link");
    rd(29, 16'h00C0, "R4 rearmed source");
    rd(4, 16'h01E1, "R4 soft reset adv");

    wr(30, 16'h00AA);
    rd(30, 16'h00AA, "R1 back to back");
    idle(1);
    idle(0);
    idle(0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule